// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block sends words out over a two-wire synchronous link on which it is the clock master. A host places each byte into a one-deep holding register. When the serial shifter has nothing to send, or in the very cycle its final bit ends, the held word moves into the shifter in a single step. The shifter then drives the data line, least significant bit first, in step with a clock that it generates from a programmable divisor. Because the next word loads the moment the previous one finishes, a host that refills the holding register in time gets an unbroken bit stream.

Two flags report progress. The holding-empty flag rises when a held word moves into the shifter and falls only when the host writes again. The interrupt-enable input gates this flag onto the interrupt line and has no effect on the flag. The shift-empty flag tells whether a word is on the wire. No interrupt is tied to it, so the host must poll it. Each word is 8 bits, or 9 bits when the nine-bit mode is selected. The ninth bit comes from a configuration input that is sampled along with the byte. The link is half-duplex, so a receive-inhibit output is asserted while a word is being shifted.

Top module: `sync_master_tx`

## Requirements
- R1: After reset, hold_empty = 0, shift_empty = 1, ser_clk = 0, ser_dat = 0, irq = 0 and rx_inhibit = 0.
- R2: A write (wr_valid = 1 at a clock edge) stores wr_byte together with mode9 and bit9_val as they are at that edge. A word written while tx_enable = 0 is held and is not sent until tx_enable returns to 1.
- R3: With tx_enable = 1, a held word moves into the shifter at the first edge where the shifter is idle or is ending its last bit. From the next cycle, hold_empty = 1. When a word is already held, a new word starts with no idle cycle and no gap in the clock.
- R4: hold_empty falls to 0 at the edge of a write and is cleared by nothing else. A write at the same edge as a transfer keeps the new byte held and leaves hold_empty = 0.
- R5: irq equals hold_empty AND irq_enable. irq_enable never changes hold_empty.
- R6: shift_empty = 1 exactly when no word is being shifted, and rx_inhibit is its complement.
- R7: A word is sent least significant bit first: bits 0..7 of the byte, followed by the ninth bit as bit 8 when mode9 was 1 at the write. ser_dat changes only while ser_clk is low and stays constant while ser_clk is high.
- R8: ser_clk idles low. Each bit holds ser_clk low for baud_div+1 cycles and then high for baud_div+1 cycles, so rising edges within a continuous stream are 2*(baud_div+1) cycles apart. Bit 0 is on ser_dat in the first cycle after the transfer.
- R9: When tx_enable is 0 at a clock edge, any word being shifted is abandoned. From the next cycle, shift_empty = 1 and ser_clk = ser_dat = 0. A word in the holding register stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmit enable; 0 aborts and idles the shifter |
| mode9 | input | 1 | Selects 9-bit words, sampled at the write |
| bit9_val | input | 1 | Ninth data bit, sampled at the write |
| irq_enable | input | 1 | Gates hold_empty onto irq |
| baud_div | input | DIV_W | Clock divisor; half period is baud_div+1 cycles |
| wr_valid | input | 1 | Host write strobe for the holding register |
| wr_byte | input | 8 | Host data byte |
| ser_clk | output | 1 | Serial clock driven by the master |
| ser_dat | output | 1 | Serial data line |
| hold_empty | output | 1 | Holding register emptied by a transfer |
| shift_empty | output | 1 | No word being shifted (polled, no interrupt) |
| irq | output | 1 | Interrupt request |
| rx_inhibit | output | 1 | Receive hold-off while transmitting |

## Verification
The delicate coincidence is a host write at the same edge as a transfer into the shifter. That edge both empties the holding register and fills it again. The bench provokes it twice. The first time, it writes the second byte in the cycle that follows the first write, with the shifter idle. The second time, it writes a byte while the previous word is in flight and requires that word to load exactly as the last bit of the word before it ends, with the divisor at zero so the edge count is exact. It judges the result from hold_empty just after each edge, from an unbroken clock period across the word boundary, and from the reassembled bit stream containing every byte in order.

// File: rtl/smtx_pkg.sv
package smtx_pkg;

    localparam int DATA_W = 8;
    localparam int WORD_W = DATA_W + 1;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef struct packed {
        logic              nine;
        logic              b8;
        logic [DATA_W-1:0] data;
    } tx_word_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    function automatic logic [WORD_W-1:0] frame_bits(tx_word_t w);
        return {(w.nine & w.b8), w.data};
    endfunction

    function automatic logic [CNT_W-1:0] frame_len(tx_word_t w);
        return w.nine ? CNT_W'(WORD_W) : CNT_W'(DATA_W);
    endfunction

endpackage

// File: rtl/smtx_hold.sv
module smtx_hold
    import smtx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  tx_word_t wr_word,
    input  logic     take,
    output tx_word_t word_q,
    output logic     full_q,
    output logic     empty_flag_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q       <= '0;
            full_q       <= 1'b0;
            empty_flag_q <= 1'b0;
        end else if (wr_en) begin
            // a write wins over a simultaneous take: old word leaves, new one stays
            word_q       <= wr_word;
            full_q       <= 1'b1;
            empty_flag_q <= 1'b0;
        end else if (take) begin
            full_q       <= 1'b0;
            empty_flag_q <= 1'b1;
        end
    end

    p_take_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (take && !wr_en) |=> (empty_flag_q && !full_q));

    p_write_clears_flag_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (!empty_flag_q && full_q));

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (empty_flag_q && !wr_en) |=> empty_flag_q);

endmodule

// File: rtl/smtx_baud.sv
module smtx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    p_count_parked_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

endmodule

// File: rtl/smtx_shift.sv
module smtx_shift
    import smtx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     load,
    input  tx_word_t load_word,
    input  logic     tick,
    output logic     busy,
    output logic     sclk,
    output logic     sdat,
    output logic     last_end
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [WORD_W-1:0] sreg;
    logic [CNT_W-1:0]  left;
    phase_e            phase;

    assign sclk     = busy && (phase == PH_HIGH);
    assign sdat     = busy && sreg[0];
    assign last_end = busy && tick && (phase == PH_HIGH) && (left == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg  <= '0;
            left  <= '0;
            busy  <= 1'b0;
            phase <= PH_LOW;
        end else if (!enable) begin
            busy  <= 1'b0;
            phase <= PH_LOW;
        end else if (load) begin
            sreg  <= frame_bits(load_word);
            left  <= frame_len(load_word);
            busy  <= 1'b1;
            phase <= PH_LOW;
        end else if (busy && tick) begin
            if (phase == PH_LOW) begin
                phase <= PH_HIGH;
            end else if (left == ONE) begin
                busy  <= 1'b0;
                phase <= PH_LOW;
            end else begin
                sreg  <= sreg >> 1;
                left  <= left - ONE;
                phase <= PH_LOW;
            end
        end
    end

    p_len_live_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (left != '0));

    p_high_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && phase == PH_HIGH && !tick && enable) |=> $stable(sdat));

    p_abort_idles_r9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!busy && !sclk && !sdat));

    p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (phase == PH_LOW));

endmodule

// File: rtl/sync_master_tx.sv
module sync_master_tx
    import smtx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_enable,
    input  logic             mode9,
    input  logic             bit9_val,
    input  logic             irq_enable,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             wr_valid,
    input  logic [7:0]       wr_byte,
    output logic             ser_clk,
    output logic             ser_dat,
    output logic             hold_empty,
    output logic             shift_empty,
    output logic             irq,
    output logic             rx_inhibit
);

    tx_word_t wr_word;
    tx_word_t held_word;
    logic     hold_full;
    logic     hold_flag;
    logic     busy;
    logic     tick;
    logic     last_end;
    logic     take;

    assign wr_word = '{nine: mode9, b8: bit9_val, data: wr_byte};
    assign take    = tx_enable && hold_full && (!busy || last_end);

    smtx_hold u_hold (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_valid),
        .wr_word      (wr_word),
        .take         (take),
        .word_q       (held_word),
        .full_q       (hold_full),
        .empty_flag_q (hold_flag)
    );

    smtx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (baud_div),
        .tick (tick)
    );

    smtx_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .enable    (tx_enable),
        .load      (take),
        .load_word (held_word),
        .tick      (tick),
        .busy      (busy),
        .sclk      (ser_clk),
        .sdat      (ser_dat),
        .last_end  (last_end)
    );

    assign hold_empty  = hold_flag;
    assign shift_empty = !busy;
    assign rx_inhibit  = busy;
    assign irq         = irq_enable && hold_flag;

    p_irq_gated_r5: assert property (@(posedge clk) disable iff (rst)
        !irq_enable |-> !irq);

    p_disabled_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tx_enable && hold_full && !wr_valid) |=> hold_full);

endmodule

// File: tb/sync_master_tx_tb.sv
module sync_master_tx_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_enable = 1'b0;
    logic       mode9 = 1'b0;
    logic       bit9_val = 1'b0;
    logic       irq_enable = 1'b0;
    logic [7:0] baud_div = 8'd1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_byte = 8'd0;
    logic       ser_clk, ser_dat, hold_empty, shift_empty, irq, rx_inhibit;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_master_tx #(.DIV_W(8)) u_dut (
        .clk(clk), .rst(rst), .tx_enable(tx_enable), .mode9(mode9),
        .bit9_val(bit9_val), .irq_enable(irq_enable), .baud_div(baud_div),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .hold_empty(hold_empty), .shift_empty(shift_empty),
        .irq(irq), .rx_inhibit(rx_inhibit)
    );

    int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0;
    int cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // serial monitor: captures bits at clock rise, checks period and stability
    logic rx_bits [0:8191];
    int   rx_n = 0;
    logic prev_clk = 1'b0, prev_dat = 1'b0;
    bit   have_rise = 0;
    int   last_rise = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_clk = 1'b0;
            have_rise = 0;
        end else begin
            if (shift_empty) have_rise = 0;
            if (ser_clk && !prev_clk) begin
                rx_bits[rx_n] = ser_dat;
                rx_n = rx_n + 1;
                if (have_rise) begin
                    mon_chk = mon_chk + 1;
                    if (cyc - last_rise != 2 * (int'(baud_div) + 1)) begin
                        mon_fail = mon_fail + 1;
                        $display("FAIL R8 clock period actual=%0d expected=%0d",
                                 cyc - last_rise, 2 * (int'(baud_div) + 1));
                    end
                end
                last_rise = cyc;
                have_rise = 1;
            end
            if (ser_clk && prev_clk) begin
                mon_chk = mon_chk + 1;
                if (ser_dat !== prev_dat) begin
                    mon_fail = mon_fail + 1;
                    $display("FAIL R7 data moved while clock high actual=%0b expected=%0b",
                             ser_dat, prev_dat);
                end
            end
            prev_clk = ser_clk;
            prev_dat = ser_dat;
        end
    end

    // expected words
    int         ew [0:255];
    bit         en9 [0:255];
    int         ne = 0;

    function automatic int word_val(input logic [7:0] d, input bit n9, input bit b);
        return n9 ? ((int'(b) << 8) | int'(d)) : int'(d);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input bit n9, input bit b);
        @(negedge clk);
        mode9 = n9; bit9_val = b; wr_byte = d; wr_valid = 1'b1;
        ew[ne] = word_val(d, n9, b); en9[ne] = n9; ne = ne + 1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_room();
        @(negedge clk);
        while (!(hold_empty || shift_empty)) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!shift_empty) @(negedge clk);
    endtask

    task automatic compare(input int base, input int first);
        int pos = base;
        for (int k = first; k < ne; k++) begin
            int nb = en9[k] ? 9 : 8;
            int got = 0;
            for (int i = 0; i < nb; i++) begin
                if (pos < rx_n && rx_bits[pos] === 1'b1) got = got | (1 << i);
                pos = pos + 1;
            end
            chk(got == ew[k], "R7 word content", got, ew[k]);
        end
        chk(pos == rx_n, "R7 bit count", rx_n - base, pos - base);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog run hung actual=%0d expected=%0d", cyc, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                     n_chk + mon_chk + 1, n_fail + mon_fail + 1);
            $finish;
        end
    end

    initial begin
        int base, first, idx_b;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(hold_empty == 1'b0, "R1 hold_empty", hold_empty, 0);
        chk(shift_empty == 1'b1, "R1 shift_empty", shift_empty, 1);
        chk(ser_clk == 1'b0 && ser_dat == 1'b0, "R1 lines idle", {ser_clk, ser_dat}, 0);
        chk(irq == 1'b0 && rx_inhibit == 1'b0, "R1 irq/rx_inhibit", {irq, rx_inhibit}, 0);

        // single word, then a second written mid-flight
        tx_enable = 1'b1; baud_div = 8'd1;
        base = rx_n; first = ne;
        @(negedge clk);
        mode9 = 1'b0; wr_byte = 8'hA5; wr_valid = 1'b1;
        ew[ne] = word_val(8'hA5, 0, 0); en9[ne] = 0; ne = ne + 1;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(shift_empty == 1'b1, "R6 idle before transfer", shift_empty, 1);
        chk(hold_empty == 1'b0, "R4 flag low after write", hold_empty, 0);
        @(negedge clk);
        chk(shift_empty == 1'b0 && rx_inhibit == 1'b1, "R6 busy after transfer",
            {shift_empty, rx_inhibit}, 1);
        chk(hold_empty == 1'b1, "R3 flag set by transfer", hold_empty, 1);
        chk(irq == 1'b0, "R5 irq masked", irq, 0);
        chk(ser_clk == 1'b0 && ser_dat == 1'b1, "R8 first bit on low clock",
            {ser_clk, ser_dat}, 1);
        irq_enable = 1'b1; #1;
        chk(irq == 1'b1, "R5 irq unmasked", irq, 1);
        chk(hold_empty == 1'b1, "R5 flag unaffected by enable", hold_empty, 1);
        irq_enable = 1'b0;
        repeat (5) @(negedge clk);
        send(8'h3C, 0, 0);
        chk(hold_empty == 1'b0, "R4 write clears flag", hold_empty, 0);
        wait_idle();
        compare(base, first);

        // coincident write and transfer, divisor zero
        baud_div = 8'd0;
        base = rx_n; first = ne;
        @(negedge clk);
        wr_byte = 8'h96; mode9 = 1'b0; wr_valid = 1'b1;
        ew[ne] = word_val(8'h96, 0, 0); en9[ne] = 0; ne = ne + 1;
        @(negedge clk);
        wr_byte = 8'h0F;
        ew[ne] = word_val(8'h0F, 0, 0); en9[ne] = 0; ne = ne + 1;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(hold_empty == 1'b0 && shift_empty == 1'b0, "R4 write at transfer edge",
            {hold_empty, shift_empty}, 0);
        repeat (15) @(negedge clk);
        chk(hold_empty == 1'b0, "R4 still held before last bit ends", hold_empty, 0);
        @(negedge clk);
        chk(hold_empty == 1'b1 && shift_empty == 1'b0, "R3 back-to-back load",
            {hold_empty, shift_empty}, 2);
        wait_idle();
        compare(base, first);

        // nine-bit words, configuration sampled at write (R2)
        baud_div = 8'd1;
        base = rx_n; first = ne;
        send(8'h81, 1, 1);
        mode9 = 1'b0; bit9_val = 1'b0;
        wait_room();
        send(8'h7E, 1, 0);
        wait_room();
        send(8'h55, 0, 1);
        wait_room();
        send(8'hC3, 1, 1);
        mode9 = 1'b0; bit9_val = 1'b0;
        wait_idle();
        compare(base, first);

        // abort mid-word, held word survives (R9, R2)
        baud_div = 8'd2;
        send(8'hE7, 0, 0);
        repeat (8) @(negedge clk);
        idx_b = ne;
        send(8'h29, 0, 0);
        tx_enable = 1'b0;
        @(negedge clk);
        chk(shift_empty == 1'b1 && rx_inhibit == 1'b0, "R9 abort idles shifter",
            {shift_empty, rx_inhibit}, 2);
        chk(ser_clk == 1'b0 && ser_dat == 1'b0, "R9 lines idle after abort",
            {ser_clk, ser_dat}, 0);
        chk(hold_empty == 1'b0, "R9 held word kept", hold_empty, 0);
        repeat (5) @(negedge clk);
        chk(shift_empty == 1'b1, "R2 no send while disabled", shift_empty, 1);
        base = rx_n;
        tx_enable = 1'b1;
        wait_idle();
        compare(base, idx_b);

        // write while disabled (R2)
        tx_enable = 1'b0;
        base = rx_n; first = ne;
        send(8'h6B, 1, 0);
        repeat (4) @(negedge clk);
        chk(shift_empty == 1'b1 && hold_empty == 1'b0, "R2 disabled write held",
            {shift_empty, hold_empty}, 2);
        tx_enable = 1'b1;
        wait_idle();
        compare(base, first);

        // constrained random batches
        for (int bt = 0; bt < 4; bt++) begin
            wait_idle();
            baud_div = 8'($urandom % 4);
            base = rx_n; first = ne;
            for (int w = 0; w < 6; w++) begin
                bit n9, b;
                logic [7:0] d;
                wait_room();
                irq_enable = 1'($urandom % 2);
                #1;
                chk(irq == (irq_enable && hold_empty), "R5 irq gating", irq,
                    int'(irq_enable && hold_empty));
                n9 = 1'($urandom % 2);
                b  = 1'($urandom % 2);
                d  = 8'($urandom);
                send(d, n9, b);
            end
            wait_idle();
            compare(base, first);
        end

        repeat (4) @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                 n_chk + mon_chk, n_fail + mon_fail);
        $finish;
    end

endmodule